// File: doc/BRIEF.md
# Video-Mode Line Packet Sequencer

This block decides, line by line, which packet headers a display serial link sends while it streams video. A timing source marks each scanline with a strobe and a line-kind code. The block then walks a pair of programmed sequence words for that kind and issues each enabled packet header on a valid/ready interface toward the lane serializer. A header is a 6-bit data identifier and a 16-bit word count. The word count is not stored in the sequence word. Each slot carries a 3-bit selector into a shared eight-entry length table, so one set of porch and payload sizes serves every line kind.

Software fills the sequence words and the length table through a simple write port before video starts. A sequence word can also ask for the link to drop back to low power once its packets have gone out. The block signals this with a one-cycle request pulse. If a new line strobe arrives before the current line has finished, the block refuses it and latches an overflow flag that only reset clears.

Top module: `dsi_line_pkt_seq`

## Requirements
- R1: After reset, hdr_valid, lp_req and seq_overflow are low, and every sequence word and length entry is zero, so a line started before any programming produces no header.
- R2: Write addresses 0 to 11 hold the sequence words, and line kind k uses word 2k as its first word and word 2k+1 as its second. Addresses 12 to 15 hold the length table: register 12+r carries entry 2r in bits [15:0] and entry 2r+1 in bits [31:16]. A write to an address from 16 to 31 changes nothing.
- R3: A sequence word holds three slots. For slot s the selector sits at bits [10s+2:10s], the identifier at bits [10s+8:10s+3] and the enable at bit 10s+9. The emitted hdr_wc is the length table entry that the selector picks.
- R4: Within a line, headers go out in the order slot 0, slot 1, slot 2 of the first word, then slot 0, slot 1, slot 2 of the second word.
- R5: A slot whose enable bit is clear produces no header, whatever its identifier and selector bits hold.
- R6: A line strobe with kind 0 to 5 is sampled on a clock edge while idle, and the first header is valid right after that edge. While hdr_ready stays high, one header is accepted per cycle. A word with no enabled slot costs one cycle with hdr_valid low.
- R7: While hdr_valid is high and hdr_ready is low, hdr_valid, hdr_id and hdr_wc hold their values.
- R8: When bit 30 of a sequence word is set, lp_req is high for exactly the one cycle after the word completes: either the cycle after the acceptance of its last enabled slot, or the cycle after its idle cycle if it has no enabled slot.
- R9: A line strobe with a valid kind that arrives while a line is still being sent is ignored and sets seq_overflow. Only reset clears seq_overflow.
- R10: A line strobe with kind 6 or 7 is ignored. It starts no line and does not set seq_overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| line_kind | input | 3 | Kind of the line being started (0 to 5) |
| line_go | input | 1 | Line start strobe |
| hdr_ready | input | 1 | Serializer accepts the current header |
| hdr_valid | output | 1 | A header is presented |
| hdr_id | output | 6 | Data identifier of the presented header |
| hdr_wc | output | 16 | Word count of the presented header |
| lp_req | output | 1 | One-cycle request to return the link to low power |
| seq_overflow | output | 1 | Sticky flag: a line strobe arrived while busy |

## Verification
The bench programs a sparse line whose disabled slots still carry nonzero identifier and selector bits. A walker that tested the wrong bit, or none at all, would send phantom headers. It stalls the serializer with irregular ready patterns and compares each held header with the one before it; a design that moved on without a handshake would drop or repeat packets. It checks the exact cycle of the low-power pulse, and the two pulses of a line whose words are both empty, so a pulse that came late, came early or was merged with another would show. It writes to out-of-range addresses that a truncating decoder would alias onto word 0. It strobes a new line while one is still in flight, and strobes with the unused kinds 6 and 7, to expose a design that restarts mid-line or treats those kinds as real lines.

// File: rtl/dsi_pkt_seq_pkg.sv
package dsi_pkt_seq_pkg;

  localparam int ID_W        = 6;
  localparam int SEL_W       = 3;
  localparam int WC_W        = 16;
  localparam int SLOTS       = 3;
  localparam int SLOT_STRIDE = 10;
  localparam int LP_BIT      = 30;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic             en;
    logic [ID_W-1:0]  id;
    logic [SEL_W-1:0] sel;
  } slot_t;

  // Unpack slot k of a sequence word.
  function automatic slot_t slot_of(input logic [WORD_W-1:0] w, input int k);
    slot_t s;
    s.sel = w[k*SLOT_STRIDE +: SEL_W];
    s.id  = w[k*SLOT_STRIDE + SEL_W +: ID_W];
    s.en  = w[k*SLOT_STRIDE + SEL_W + ID_W];
    return s;
  endfunction

  // One bit per slot: set when that slot is enabled.
  function automatic logic [SLOTS-1:0] enable_mask(input logic [WORD_W-1:0] w);
    logic [SLOTS-1:0] m;
    for (int k = 0; k < SLOTS; k++) m[k] = slot_of(w, k).en;
    return m;
  endfunction

  function automatic logic lp_flag(input logic [WORD_W-1:0] w);
    return w[LP_BIT];
  endfunction

  // Select one 16-bit half of a packed length pair: odd index in the upper half.
  function automatic logic [WC_W-1:0] pair_half(input logic [2*WC_W-1:0] r, input logic odd);
    return odd ? r[2*WC_W-1:WC_W] : r[WC_W-1:0];
  endfunction

endpackage

// File: rtl/seq_word_store.sv
module seq_word_store
  import dsi_pkt_seq_pkg::*;
#(
  parameter int NUM_WORDS = 12,
  parameter int ADDR_W    = 5,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    // Full-width compare: addresses above the map never alias onto a word (R2).
    logic hit;
    assign hit = cfg_we && (int'(cfg_addr) == g);
    always_ff @(posedge clk) begin
      if (!rst_n)   words[g] <= '0;
      else if (hit) words[g] <= cfg_wdata;
    end
  end

  assign rd_word = (int'(rd_idx) < NUM_WORDS) ? words[rd_idx] : '0;

endmodule

// File: rtl/wc_table.sv
module wc_table
  import dsi_pkt_seq_pkg::*;
#(
  parameter int NUM_LEN   = 8,
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 12,
  localparam int NUM_REGS = NUM_LEN / 2,
  localparam int LSEL_W   = $clog2(NUM_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [LSEL_W-1:0] sel,
  output logic [WC_W-1:0]   wc
);

  logic [2*WC_W-1:0] pairs [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_pair
    logic hit;
    assign hit = cfg_we && (int'(cfg_addr) == BASE_ADDR + r);
    always_ff @(posedge clk) begin
      if (!rst_n)   pairs[r] <= '0;
      else if (hit) pairs[r] <= cfg_wdata[2*WC_W-1:0];
    end
  end

  assign wc = pair_half(pairs[sel[LSEL_W-1:1]], sel[0]);

endmodule

// File: rtl/slot_walker.sv
module slot_walker
  import dsi_pkt_seq_pkg::*;
#(
  parameter int NUM_KINDS = 6,
  localparam int KIND_W   = $clog2(NUM_KINDS),
  localparam int IDX_W    = $clog2(2 * NUM_KINDS),
  localparam int SPTR_W   = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_go,
  input  logic [KIND_W-1:0] line_kind,
  input  logic [WORD_W-1:0] word,
  input  logic              hdr_ready,
  input  logic              cfg_we,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              hdr_valid,
  output logic [ID_W-1:0]   hdr_id,
  output logic [SEL_W-1:0]  hdr_sel,
  output logic              lp_req,
  output logic              seq_overflow
);

  logic              busy_q;
  logic [IDX_W-1:0]  base_q;
  logic              half_q;
  logic [SPTR_W-1:0] slot_q;
  logic              lp_q;
  logic              ovf_q;

  // Named events for the assertions
  logic              kind_ok;
  logic              line_start;
  logic              line_clash;
  logic              slot_accept;
  logic              word_done;

  logic [SLOTS-1:0]  mask;
  logic [SLOTS-1:0]  rem;
  logic [SLOTS-1:0]  after;
  logic [SPTR_W-1:0] first;
  logic              found;
  logic              last;
  slot_t             cur;

  assign rd_idx = base_q + IDX_W'(half_q);
  assign mask   = enable_mask(word);

  // Find the first enabled slot at or beyond the slot pointer.
  always_comb begin
    rem   = '0;
    first = '0;
    found = 1'b0;
    for (int k = 0; k < SLOTS; k++) rem[k] = mask[k] && (k >= int'(slot_q));
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (rem[k]) begin
        first = SPTR_W'(k);
        found = 1'b1;
      end
    end
    after = rem;
    for (int k = 0; k < SLOTS; k++) if (k == int'(first)) after[k] = 1'b0;
    last = (after == '0);
  end

  assign cur         = slot_of(word, int'(first));
  assign hdr_valid   = busy_q && found;
  assign hdr_id      = cur.id;
  assign hdr_sel     = cur.sel;
  assign slot_accept = hdr_valid && hdr_ready;
  assign word_done   = busy_q && (!found || (slot_accept && last));

  assign kind_ok    = int'(line_kind) < NUM_KINDS;
  assign line_start = line_go && kind_ok && !busy_q;
  assign line_clash = line_go && kind_ok && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      half_q <= 1'b0;
      slot_q <= '0;
      lp_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      lp_q <= word_done && lp_flag(word);
      if (line_clash) ovf_q <= 1'b1;
      if (line_start) begin
        busy_q <= 1'b1;
        base_q <= IDX_W'(2 * int'(line_kind));
        half_q <= 1'b0;
        slot_q <= '0;
      end else if (word_done) begin
        if (!half_q) begin
          half_q <= 1'b1;
          slot_q <= '0;
        end else begin
          busy_q <= 1'b0;
        end
      end else if (slot_accept) begin
        slot_q <= first + SPTR_W'(1);
      end
    end
  end

  assign lp_req       = lp_q;
  assign seq_overflow = ovf_q;

  // R7: a stalled header holds until it is taken
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready && !cfg_we) |=> (hdr_valid && $stable(hdr_id) && $stable(hdr_sel)));

  // R9: overflow is sticky
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_overflow |=> seq_overflow);

  // R9: a clash while busy raises the flag on the next cycle
  assert_clash_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_clash |=> seq_overflow);

  // R6: an accepted start makes the walker busy on the next cycle
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> busy_q);

  // R10: an unused kind while idle leaves the walker idle
  assert_bad_kind_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_go && !kind_ok && !busy_q) |=> !busy_q);

  // R8: a low-power pulse only follows a cycle spent on a line
  assert_lp_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> $past(busy_q));

endmodule

// File: rtl/dsi_line_pkt_seq.sv
module dsi_line_pkt_seq
  import dsi_pkt_seq_pkg::*;
#(
  parameter int NUM_KINDS  = 6,
  parameter int NUM_LEN    = 8,
  parameter int ADDR_W     = 5,
  localparam int KIND_W    = $clog2(NUM_KINDS),
  localparam int NUM_WORDS = 2 * NUM_KINDS,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int LSEL_W    = $clog2(NUM_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [KIND_W-1:0] line_kind,
  input  logic              line_go,
  input  logic              hdr_ready,
  output logic              hdr_valid,
  output logic [5:0]        hdr_id,
  output logic [15:0]       hdr_wc,
  output logic              lp_req,
  output logic              seq_overflow
);

  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  sel;

  seq_word_store #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_idx(rd_idx), .rd_word(word)
  );

  wc_table #(.NUM_LEN(NUM_LEN), .ADDR_W(ADDR_W), .BASE_ADDR(NUM_WORDS)) u_len (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel(sel[LSEL_W-1:0]), .wc(hdr_wc)
  );

  slot_walker #(.NUM_KINDS(NUM_KINDS)) u_walk (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .line_kind(line_kind),
    .word(word), .hdr_ready(hdr_ready), .cfg_we(cfg_we), .rd_idx(rd_idx),
    .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_sel(sel),
    .lp_req(lp_req), .seq_overflow(seq_overflow)
  );

  // R1: nothing is presented while in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!hdr_valid && !lp_req && !seq_overflow));

endmodule

// File: tb/tb_dsi_line_pkt_seq.sv
module tb_dsi_line_pkt_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  line_kind = '0;
  logic        line_go = 1'b0;
  logic        hdr_ready = 1'b0;
  logic        hdr_valid;
  logic [5:0]  hdr_id;
  logic [15:0] hdr_wc;
  logic        lp_req;
  logic        seq_overflow;

  always #4 clk = ~clk;  // 125 MHz

  dsi_line_pkt_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_kind(line_kind), .line_go(line_go),
    .hdr_ready(hdr_ready), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .hdr_wc(hdr_wc), .lp_req(lp_req), .seq_overflow(seq_overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] mw [12];
  logic [15:0] mlen [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // Slot field: {enable, id, selector} in 10 bits
  function automatic logic [9:0] sl(input logic en, input logic [5:0] id, input logic [2:0] s);
    return {en, id, s};
  endfunction

  function automatic logic [31:0] wd(input logic lp, input logic [9:0] s0,
                                     input logic [9:0] s1, input logic [9:0] s2);
    return {1'b0, lp, s2, s1, s0};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int k);
    line_go = 1'b1; line_kind = 3'(k);
    @(negedge clk);
    line_go = 1'b0;
  endtask

  // Run one line and compare each accepted header against the model.
  task automatic run_line(input int k, input logic [7:0] pat, input string tag);
    logic [5:0]  eid [6];
    logic [15:0] ewc [6];
    int ne = 0, got = 0, elp = 0, nlp = 0;
    logic held = 1'b0;
    logic [5:0] hid = '0;
    logic [15:0] hwc = '0;
    for (int h = 0; h < 2; h++) begin
      logic [31:0] w;
      w = mw[2*k+h];
      for (int s = 0; s < 3; s++) begin
        if (w[s*10+9]) begin
          eid[ne] = w[s*10+3 +: 6];
          ewc[ne] = mlen[w[s*10 +: 3]];
          ne++;
        end
      end
      if (w[30]) elp++;
    end
    strobe(k);
    for (int c = 0; c < 40; c++) begin
      if (lp_req) nlp++;
      if (held)
        chk(hdr_valid && hdr_id == hid && hdr_wc == hwc, "R7 stalled header moved",
            {hdr_id, hdr_wc}, {hid, hwc});
      held = 1'b0;
      hdr_ready = pat[c % 8];
      if (hdr_valid) begin
        if (hdr_ready) begin
          if (got < ne)
            chk(hdr_id == eid[got] && hdr_wc == ewc[got], {tag, " R3 R4 header"},
                {hdr_id, hdr_wc}, {eid[got], ewc[got]});
          got++;
        end else begin
          held = 1'b1; hid = hdr_id; hwc = hdr_wc;
        end
      end
      @(negedge clk);
    end
    hdr_ready = 1'b0;
    chk(got == ne, {tag, " R5 header count"}, got, ne);
    chk(nlp == elp, {tag, " R8 lp pulse count"}, nlp, elp);
  endtask

  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'hFF}, {3'd1, 8'hFF}, {3'd2, 8'hFF}, {3'd3, 8'hFF},
    {3'd3, 8'hA5}, {3'd4, 8'hFF}, {3'd5, 8'hFF}, {3'd3, 8'h81}
  };

  initial begin
    for (int i = 0; i < 12; i++) mw[i] = '0;
    for (int i = 0; i < 8; i++) mlen[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!hdr_valid, "R1 hdr_valid after reset", hdr_valid, 0);
    chk(!lp_req, "R1 lp_req after reset", lp_req, 0);
    chk(!seq_overflow, "R1 overflow after reset", seq_overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_line(3, 8'hFF, "R1 unprogrammed");

    // Length table (R2 pairing)
    mlen[0] = 16'd0;   mlen[1] = 16'd10;  mlen[2] = 16'd20;  mlen[3] = 16'd1440;
    mlen[4] = 16'd30;  mlen[5] = 16'h55;  mlen[6] = 16'h66;  mlen[7] = 16'h0F0F;
    for (int r = 0; r < 4; r++) wr(12 + r, {mlen[2*r+1], mlen[2*r]});

    mw[0]  = wd(1, sl(1, 6'h01, 0), sl(1, 6'h19, 1), sl(1, 6'h31, 0));
    mw[2]  = wd(1, sl(1, 6'h11, 0), sl(1, 6'h19, 1), sl(1, 6'h31, 0));
    mw[4]  = wd(1, sl(1, 6'h21, 0), sl(1, 6'h19, 1), sl(1, 6'h31, 0));
    mw[6]  = wd(0, sl(1, 6'h21, 0), sl(1, 6'h19, 1), sl(1, 6'h31, 0));
    mw[7]  = wd(0, sl(1, 6'h19, 2), sl(1, 6'h3E, 3), sl(1, 6'h19, 4));
    mw[8]  = wd(0, sl(0, 6'h2A, 5), sl(1, 6'h08, 7), sl(0, 6'h15, 6));
    mw[9]  = wd(1, sl(0, 6'h3F, 3), sl(0, 6'h33, 1), sl(1, 6'h0C, 5));
    mw[10] = wd(1, sl(0, 6'h3F, 7), sl(0, 6'h00, 0), sl(0, 6'h01, 1));
    mw[11] = wd(1, 10'h0, 10'h0, 10'h0);
    for (int i = 0; i < 12; i++) wr(i, mw[i]);
    // R2: out-of-range addresses must not alias onto the map
    wr(16, 32'h3FFF_FFFF);
    wr(28, 32'h3FFF_FFFF);
    wr(31, 32'h3FFF_FFFF);

    for (int v = 0; v < NV; v++)
      run_line(int'(VEC[v][10:8]), VEC[v][7:0], $sformatf("vec%0d R2", v));

    // R6 and R8: exact timing of a line with kind 2, ready always high
    hdr_ready = 1'b1;
    strobe(2);
    chk(hdr_valid && hdr_id == 6'h21, "R6 first header right after start", hdr_id, 6'h21);
    @(negedge clk);
    chk(hdr_valid && hdr_id == 6'h19 && hdr_wc == 16'd10, "R6 second header next cycle", hdr_wc, 10);
    @(negedge clk);
    chk(hdr_valid && hdr_id == 6'h31 && !lp_req, "R6 third header", hdr_id, 6'h31);
    @(negedge clk);
    chk(lp_req && !hdr_valid, "R8 lp pulse after last accept", lp_req, 1);
    @(negedge clk);
    chk(!lp_req && !hdr_valid, "R8 lp pulse one cycle", lp_req, 0);
    @(negedge clk);
    hdr_ready = 1'b0;

    // R10: unused kinds are ignored
    strobe(6);
    strobe(7);
    for (int c = 0; c < 4; c++) begin
      chk(!hdr_valid && !lp_req, "R10 unused kind produced output", hdr_valid, 0);
      @(negedge clk);
    end
    chk(!seq_overflow, "R10 unused kind set overflow", seq_overflow, 0);
    run_line(2, 8'hFF, "R10 after unused kind");

    // R9: a second strobe mid-line is ignored and flagged
    begin
      int got = 0;
      hdr_ready = 1'b0;
      strobe(3);
      strobe(0);
      chk(seq_overflow, "R9 overflow set", seq_overflow, 1);
      for (int c = 0; c < 20; c++) begin
        hdr_ready = 1'b1;
        if (hdr_valid) begin
          if (got == 0) chk(hdr_id == 6'h21, "R9 line kept its first header", hdr_id, 6'h21);
          got++;
        end
        @(negedge clk);
      end
      hdr_ready = 1'b0;
      chk(got == 6, "R9 only the running line was sent", got, 6);
    end
    run_line(1, 8'hFF, "R9 later line");
    chk(seq_overflow, "R9 overflow sticky", seq_overflow, 1);

    summary();
    $finish;
  end

endmodule